// File: doc/BRIEF.md
# Soft Power Ramp Sequencer

This block sits in front of an audio converter and wraps a stereo sample stream in a gain envelope. When the converter is switched on or off, the output never jumps. A power request input selects the target condition. A strobe at the input sample rate (1 fs) moves an envelope position by one step per sample toward the target. Each strobed sample pair is scaled by the gain at the current position. A DC bias that follows the same position is then added.

The envelope has 640 positions in two phases. Positions 0 to 512 form the DC phase. Here the signal is muted, and the bias climbs linearly from zero to a fixed peak. Positions 512 to 640 form the raised-cosine phase. Here the bias stays at its peak and the signal gain follows a half cosine from zero to unity. Power-up walks the positions upward and power-down walks them downward. A full transition therefore takes 640 sample periods, about 14.5 ms at 44.1 kHz. If the request changes partway through, the walk turns around at the position it has reached. A 2-bit status output tells the rest of the system whether the path is off, ramping up, fully on or ramping down.

Top module: `soft_ramp_seq`

## Requirements
- R1: After reset the envelope position is 0, `ramp_state` is 2'b00 (off), `out_vld` is 0 and both output samples are 0.
- R2: The position changes only in a cycle where `smp_stb` is high, and then by exactly one step. It moves up when `pwr_req` is 1 and below 640, and down when `pwr_req` is 0 and above 0. Without a strobe a change of `pwr_req` has no effect on the state or on the outputs.
- R3: Starting from off with `pwr_req` held at 1, `ramp_state` reads 2'b01 after each of the first 639 strobes and 2'b10 after the 640th.
- R4: At positions 0 through 512 the signal gain is 0. The added bias is floor(2048 × position / 512). At positions 512 and above the bias is 2048.
- R5: At position 512 + k, for k = 1 to 128, the gain is round(16384 × (1 − cos(πk/128))) in units of 1/32768. Gain 32768 (unity) is reached at position 640.
- R6: Each output sample equals (sample × gain + 16384) >> 15 (an arithmetic shift) plus the bias. It uses the position held before the strobe that captured the sample.
- R7: Starting from fully on with `pwr_req` held at 0, `ramp_state` reads 2'b11 after each of the first 639 strobes and 2'b00 after the 640th.
- R8: A change of `pwr_req` mid-ramp reverses the direction from the position already reached, with no jump. The next step is one position the other way.
- R9: `ramp_state` encoding: 2'b00 off (position 0, request 0), 2'b01 ramping up, 2'b10 on (position 640, request 1), 2'b11 ramping down. The direction is the request captured at the last strobe.
- R10: `out_vld` is high for exactly the one cycle after each strobe. The output samples hold their values between strobes.
- R11: If the scaled sample plus bias leaves the 24-bit signed range, the output saturates to 24'h7FFFFF or 24'h800000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req | input | 1 | 1 requests power on, 0 requests power off; sampled on strobes |
| smp_stb | input | 1 | One-cycle strobe per input sample (1 fs) |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| out_l | output | 24 | Left output sample, signed |
| out_r | output | 24 | Right output sample, signed |
| out_vld | output | 1 | Output samples updated this cycle |
| ramp_state | output | 2 | Envelope status, encoded per R9 |

## Verification
The hardest case is a request reversal that lands inside the raised-cosine phase, followed by a second reversal deep in the DC phase. The first has to hit between positions 513 and 639, and the second below 512. Only a long, counted run of strobes can get there. The stimulus therefore climbs to full power and holds a while, with full-scale samples to push the bias into saturation. It then drops 100 positions into the cosine phase and climbs 20. Next it descends through both phases to off, climbs 300 and comes back down. A model position in the bench predicts every sample and every status value along that path.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'b00,
    ST_UP  = 2'b01,
    ST_ON  = 2'b10,
    ST_DN  = 2'b11
  } ramp_st_e;

  // Half-cosine rise from 0 to unity over n steps, evaluated at step k.
  function automatic int rc_point(int k, int n, int unity);
    real ph;
    ph = 3.14159265358979 * real'(k) / real'(n);
    return $rtoi(real'(unity) / 2.0 * (1.0 - $cos(ph)) + 0.5);
  endfunction

endpackage

// File: rtl/srs_position.sv
module srs_position
  import srs_pkg::*;
#(
  parameter int DC_LEN  = 512,
  parameter int COS_LEN = 128,
  parameter int PW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          req,
  output logic [PW-1:0] pos_o,
  output ramp_st_e      state_o
);

  localparam int TOTAL = DC_LEN + COS_LEN;
  localparam logic [PW-1:0] TOP_POS = PW'(TOTAL);

  logic [PW-1:0] pos_q;
  logic          dir_q;
  logic          at_top;
  logic          at_bot;
  logic          step_up;
  logic          step_dn;

  assign at_top  = (pos_q == TOP_POS);
  assign at_bot  = (pos_q == '0);
  assign step_up = stb &&  req && !at_top;
  assign step_dn = stb && !req && !at_bot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      dir_q <= 1'b0;
    end else if (stb) begin
      dir_q <= req;
      if (step_up)      pos_q <= pos_q + 1'b1;
      else if (step_dn) pos_q <= pos_q - 1'b1;
    end
  end

  always_comb begin
    if (dir_q) state_o = at_top ? ST_ON  : ST_UP;
    else       state_o = at_bot ? ST_OFF : ST_DN;
  end

  assign pos_o = pos_q;

  // R2: position frozen without a strobe
  a_r2_hold_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(pos_q));

  // R2/R8: any move is a single step
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + 1'b1) ||
            (pos_q + 1'b1 == $past(pos_q)));

  // R3: never past the last position
  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= TOP_POS);

  // R9: a strobe with request high never leaves the path off or ramping down
  a_r9_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && req) |=> (state_o == ST_UP || state_o == ST_ON));

endmodule

// File: rtl/srs_gain_lut.sv
module srs_gain_lut
  import srs_pkg::*;
#(
  parameter int DC_LEN  = 512,
  parameter int COS_LEN = 128,
  parameter int PW      = 10,
  parameter int GW      = 16,
  parameter int FRAC    = 15
) (
  input  logic [PW-1:0] pos,
  output logic [GW-1:0] gain_o
);

  localparam int UNITY = 1 << FRAC;
  localparam int IW    = $clog2(COS_LEN + 1);
  localparam logic [PW-1:0] DC_POS = PW'(DC_LEN);

  logic [GW-1:0] tbl [COS_LEN+1];
  logic [PW-1:0] rel;
  logic [IW-1:0] idx;

  for (genvar k = 0; k <= COS_LEN; k++) begin : g_pt
    localparam logic [GW-1:0] PT = GW'(rc_point(k, COS_LEN, UNITY));
    assign tbl[k] = PT;
  end

  assign rel = pos - DC_POS;
  assign idx = rel[IW-1:0];

  always_comb begin
    if (pos <= DC_POS) gain_o = '0;
    else               gain_o = tbl[idx];
  end

endmodule

// File: rtl/srs_scaler.sv
module srs_scaler #(
  parameter int DW   = 24,
  parameter int GW   = 16,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic signed [DW-1:0] smp,
  input  logic        [GW-1:0] gain,
  input  logic        [DW-1:0] dc,
  output logic signed [DW-1:0] out_o
);

  localparam int PRW = DW + GW + 1;

  function automatic logic signed [DW-1:0] mul_round(logic signed [DW-1:0] s,
                                                     logic [GW-1:0] g);
    logic signed [PRW-1:0] p;
    p = s * $signed({1'b0, g});
    p = p + $signed(PRW'(1 << (FRAC - 1)));
    p = p >>> FRAC;
    return p[DW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] sat_add(logic signed [DW-1:0] s,
                                                   logic [DW-1:0] b);
    logic signed [DW:0] t;
    t = {s[DW-1], s} + $signed({1'b0, b});
    if (t[DW] != t[DW-1])
      return t[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    return t[DW-1:0];
  endfunction

  logic signed [DW-1:0] scaled;
  logic signed [DW-1:0] out_q;

  assign scaled = mul_round(smp, gain);

  always_ff @(posedge clk) begin
    if (!rst_n)   out_q <= '0;
    else if (stb) out_q <= sat_add(scaled, dc);
  end

  assign out_o = out_q;

  // R10: output holds between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(out_q));

  // R4: muted, unbiased input gives zero
  a_r4_silent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && gain == '0 && dc == '0) |=> out_q == '0);

endmodule

// File: rtl/soft_ramp_seq.sv
module soft_ramp_seq
  import srs_pkg::*;
#(
  parameter int DW      = 24,
  parameter int GW      = 16,
  parameter int FRAC    = 15,
  parameter int DC_LEN  = 512,
  parameter int COS_LEN = 128,
  parameter int DC_PEAK = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_req,
  input  logic          smp_stb,
  input  logic [DW-1:0] in_l,
  input  logic [DW-1:0] in_r,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic          out_vld,
  output logic [1:0]    ramp_state
);

  localparam int TOTAL = DC_LEN + COS_LEN;
  localparam int PW    = $clog2(TOTAL + 1);
  localparam int NCH   = 2;
  localparam logic [PW-1:0] TOP_POS = PW'(TOTAL);
  localparam logic [PW-1:0] DC_POS  = PW'(DC_LEN);
  localparam logic [GW-1:0] UNITY_G = GW'(1 << FRAC);

  function automatic logic [DW-1:0] dc_level(logic [PW-1:0] p);
    int pv;
    pv = int'(p);
    if (pv >= DC_LEN) return DW'(DC_PEAK);
    return DW'((pv * DC_PEAK) / DC_LEN);
  endfunction

  logic [PW-1:0] pos;
  ramp_st_e      state;
  logic [GW-1:0] gain;
  logic [DW-1:0] dc;
  logic          vld_q;
  logic [DW-1:0] ch_in  [NCH];
  logic [DW-1:0] ch_out [NCH];

  srs_position #(.DC_LEN(DC_LEN), .COS_LEN(COS_LEN), .PW(PW)) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (smp_stb),
    .req    (pwr_req),
    .pos_o  (pos),
    .state_o(state)
  );

  srs_gain_lut #(.DC_LEN(DC_LEN), .COS_LEN(COS_LEN), .PW(PW), .GW(GW),
                 .FRAC(FRAC)) u_lut (
    .pos   (pos),
    .gain_o(gain)
  );

  assign dc = dc_level(pos);

  assign ch_in[0] = in_l;
  assign ch_in[1] = in_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    srs_scaler #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_scl (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (smp_stb),
      .smp  (ch_in[c]),
      .gain (gain),
      .dc   (dc),
      .out_o(ch_out[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= smp_stb;
  end

  assign out_l      = ch_out[0];
  assign out_r      = ch_out[1];
  assign out_vld    = vld_q;
  assign ramp_state = state;

  // R4: the lookup stays muted through the DC phase
  a_r4_dc_mute: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= DC_POS |-> gain == '0);

  // R5: unity gain at the last position
  a_r5_unity_top: assert property (@(posedge clk) disable iff (!rst_n)
    pos == TOP_POS |-> gain == UNITY_G);

  // R10: valid pulse tracks the strobe
  a_r10_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_vld);
  a_r10_vld_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !out_vld);

  // R1: a strobe at position 0 yields silence on both channels
  a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && pos == '0) |=> (out_l == '0 && out_r == '0));

endmodule

// File: tb/soft_ramp_seq_tb_top.sv
module soft_ramp_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_req = 1'b0;
  logic        smp_stb = 1'b0;
  logic [23:0] in_l = '0;
  logic [23:0] in_r = '0;
  logic [23:0] out_l;
  logic [23:0] out_r;
  logic        out_vld;
  logic [1:0]  ramp_state;

  always #5 clk = ~clk;

  soft_ramp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .smp_stb(smp_stb),
    .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
    .out_vld(out_vld), .ramp_state(ramp_state)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int m_pos = 0;
  bit m_dir = 0;
  logic [47:0] exp_q [$];
  int stepno = 0;

  function automatic int exp_gain(int p);
    if (p <= 512) return 0;
    return $rtoi(16384.0 * (1.0 - $cos(3.14159265358979 * real'(p - 512) / 128.0)) + 0.5);
  endfunction

  function automatic int exp_dc(int p);
    if (p >= 512) return 2048;
    return p * 4;
  endfunction

  function automatic logic [23:0] exp_out(logic [23:0] s, int p);
    longint v;
    v = ((longint'($signed(s)) * longint'(exp_gain(p))) + 16384) >>> 15;
    v = v + longint'(exp_dc(p));
    if (v > 64'sd8388607)  v = 64'sd8388607;
    if (v < -64'sd8388608) v = -64'sd8388608;
    return v[23:0];
  endfunction

  function automatic logic [1:0] exp_state();
    if (m_dir) return (m_pos == 640) ? 2'b10 : 2'b01;
    return (m_pos == 0) ? 2'b00 : 2'b11;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (pos %0d)", req, act, exp, m_pos);
    end
  endtask

  // monitor: scoreboard pop (R6, R10)
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected valid", 64'd1, 64'd0);
      end else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        check("R6 left sample", {40'd0, out_l}, {40'd0, e[47:24]});
        check("R6 right sample", {40'd0, out_r}, {40'd0, e[23:0]});
      end
    end
  end

  // driver: one strobe, then one idle cycle
  task automatic step(bit req, logic [23:0] l, logic [23:0] r);
    pwr_req = req; in_l = l; in_r = r; smp_stb = 1'b1;
    exp_q.push_back({exp_out(l, m_pos), exp_out(r, m_pos)});
    @(negedge clk);
    smp_stb = 1'b0;
    m_dir = req;
    if (req && m_pos < 640) m_pos++;
    else if (!req && m_pos > 0) m_pos--;
    check("R9 status", {62'd0, ramp_state}, {62'd0, exp_state()});
    @(negedge clk);
    check("R10 held valid low", {63'd0, out_vld}, 64'd0);
  endtask

  task automatic steps(bit req, int n);
    for (int i = 0; i < n; i++) begin
      logic [23:0] a;
      stepno++;
      a = 24'(stepno * 40503 + 12345);
      if (stepno % 37 == 0) a = 24'h7FFFFF;
      if (stepno % 41 == 0) a = 24'h800000;
      step(req, a, ~a);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", {62'd0, ramp_state}, 64'd0);
    check("R1 valid", {63'd0, out_vld}, 64'd0);
    check("R1 out_l", {40'd0, out_l}, 64'd0);
    check("R1 out_r", {40'd0, out_r}, 64'd0);

    // R2: request without strobe does nothing
    pwr_req = 1'b1; in_l = 24'h123456;
    repeat (5) @(negedge clk);
    check("R2 no-strobe status", {62'd0, ramp_state}, 64'd0);
    check("R2 no-strobe valid", {63'd0, out_vld}, 64'd0);
    check("R2 no-strobe out", {40'd0, out_l}, 64'd0);

    // R3 / R4 / R5: full power-up
    steps(1, 639);
    check("R3 still ramping at 639", {62'd0, ramp_state}, 64'd1);
    steps(1, 1);
    check("R3 on at 640", {62'd0, ramp_state}, 64'd2);

    // R11: saturation at full gain with bias
    step(1, 24'h7FFFFF, 24'h800000);
    step(1, 24'h7FFF00, 24'h800001);
    steps(1, 3);

    // R8: reverse inside the cosine phase, then again in DC phase
    steps(0, 100);
    check("R8 down from on", {62'd0, ramp_state}, 64'd3);
    steps(1, 20);
    check("R8 reversed up", {62'd0, ramp_state}, 64'd1);
    steps(0, 560);
    check("R7 off after descent", {62'd0, ramp_state}, 64'd0);
    steps(1, 300);
    steps(0, 299);
    check("R8 one step above off", {62'd0, ramp_state}, 64'd3);
    steps(0, 1);
    check("R8 off again", {62'd0, ramp_state}, 64'd0);

    // R7: full power-down from fully on
    steps(1, 640);
    check("R3 on again", {62'd0, ramp_state}, 64'd2);
    steps(0, 639);
    check("R7 still ramping at 639", {62'd0, ramp_state}, 64'd3);
    steps(0, 1);
    check("R7 off at 640", {62'd0, ramp_state}, 64'd0);

    // R2: request change without strobe at off
    pwr_req = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 idle status", {62'd0, ramp_state}, 64'd0);

    repeat (3) @(negedge clk);
    check("R10 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule